// File: doc/BRIEF.md
# FDX-B Transponder Frame Transmitter

This block is the digital heart of a passive, read-only identification tag. Three data fields (an identifier, a check word and an extension word) enter on input ports. The block packs them into a 128-bit frame. It adds an 11-bit sync header and a stuffed control bit of value 1 after every eight data bits. It then sends the frame serially, one bit per 32 carrier clocks, and repeats it back to back for as long as the power-good reset stays released.

Each bit is coded as a differential biphase line level on an active-low modulation control output. A low level asks the coil driver outside the block to sink a high load current. An advance setting can make every high-to-low output edge happen a few clocks early, which helps a driver that is slow to switch off. Edges going from low to high are never moved.

The block also reports the index of the bit being sent and a strobe that marks the first clock of each repetition. The field contents and the advance setting are taken only at the start of a frame. The frame on the air therefore never mixes two versions of the data.

Top module: `fdxb_tx`

## Requirements
- R1: Reset is synchronous and active low. At every clock edge where `rst_n` is low, `mod_n` becomes 1, `bit_idx` becomes 0 and `frame_start` becomes 0, and both the clock-in-bit and bit counters are cleared.
- R2: Each bit occupies exactly 32 consecutive clocks. `bit_idx` holds the frame position being sent and counts 0 to 127, then wraps to 0 with no idle clock.
- R3: `frame_start` is high for exactly one clock: the first clock of bit index 0 in each repetition. The first such clock is the first edge after reset is released.
- R4: Transmission begins with frame position 0 on the first edge after reset release.
- R5: With advance 0, the nominal line level toggles on clock 0 of every bit. For a 1 it holds for the rest of the bit. For a 0 it toggles again on clock 16 (clocks numbered 0 to 31 within the bit). `mod_n` carries this level directly. Before the first bit the level is high, so the first bit starts low.
- R6: The frame layout is fixed. Positions 0 to 9 are 0 and position 10 is 1. Positions 11 to 82 carry `id_code` in eight groups, each group being eight data bits, least significant first, followed by a 1. Positions 83 to 100 carry `crc_code` in two such groups. Positions 101 to 127 carry `ext_code` in three such groups.
- R7: With advance A (0 to 8), every high-to-low edge of `mod_n` occurs A clocks before the matching nominal edge. Every low-to-high edge stays at its nominal clock.
- R8: An `adv_in` value above 8 behaves exactly as 8.
- R9: `id_code`, `crc_code`, `ext_code` and `adv_in` are taken only on the first clock of a frame. Changing them at any other time has no effect on the frame already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Power-good reset, synchronous, active low |
| id_code | input | 64 | Identifier field, least significant bit sent first |
| crc_code | input | 16 | Check word field, least significant bit sent first |
| ext_code | input | 24 | Extension field, least significant bit sent first |
| adv_in | input | 4 | Falling-edge advance in clocks; values above 8 act as 8 |
| mod_n | output | 1 | Modulation control; low requests high coil load |
| bit_idx | output | 7 | Frame position currently being sent |
| frame_start | output | 1 | One-clock strobe on the first clock of every frame |

## Verification
The hardest behaviour to reach is a falling edge that is pulled across a bit boundary or across the wrap from position 127 to position 0. At that point the look-ahead must predict the next bit's opening toggle before that bit, or a new frame, has been taken. The stimulus reaches it by running whole frames at advances 5, 8 and a clamped 15. It also changes the fields and the advance halfway through a frame, so that the next frame starts with data and an advance different from the frame that is ending. A reset pulse is also applied in the middle of a frame, so that the bench checks the restart path from a non-zero bit position.

// File: rtl/fdxb_pkg.sv
// fdxb_pkg: shared defaults for the biphase frame transmitter.
// Assumes every data field width is a whole number of stuffing groups.
package fdxb_pkg;
    localparam int DEF_BIT_CLKS  = 32;
    localparam int DEF_ID_W      = 64;
    localparam int DEF_CRC_W     = 16;
    localparam int DEF_EXT_W     = 24;
    localparam int DEF_GRP_W     = 8;
    localparam int DEF_HDR_ZEROS = 10;
    localparam int DEF_MAX_ADV   = 8;
    localparam int DEF_ADV_IN_W  = 4;

    // Total frame length for a given field set, header and stuffing rule.
    function automatic int frame_len(input int id_w, input int crc_w,
                                     input int ext_w, input int grp_w,
                                     input int hdr_zeros);
        return hdr_zeros + 1 + ((id_w + crc_w + ext_w) / grp_w) * (grp_w + 1);
    endfunction
endpackage

// File: rtl/fdxb_frame_pack.sv
// fdxb_frame_pack: builds the full serial frame from the three data fields.
// Position 0 is sent first. The header is HDR_ZEROS zeros then a single 1.
// The fields are concatenated id, crc, ext (each LSB first) and a 1 follows
// every GRP_W data bits. Purely combinational.
module fdxb_frame_pack #(
    parameter int ID_W      = fdxb_pkg::DEF_ID_W,
    parameter int CRC_W     = fdxb_pkg::DEF_CRC_W,
    parameter int EXT_W     = fdxb_pkg::DEF_EXT_W,
    parameter int GRP_W     = fdxb_pkg::DEF_GRP_W,
    parameter int HDR_ZEROS = fdxb_pkg::DEF_HDR_ZEROS,
    parameter int FRAME_W   = fdxb_pkg::frame_len(ID_W, CRC_W, EXT_W, GRP_W, HDR_ZEROS)
) (
    input  logic [ID_W-1:0]    id_code,
    input  logic [CRC_W-1:0]   crc_code,
    input  logic [EXT_W-1:0]   ext_code,
    output logic [FRAME_W-1:0] frame
);
    localparam int DATA_W = ID_W + CRC_W + EXT_W;
    localparam int N_GRP  = DATA_W / GRP_W;
    localparam int HDR_W  = HDR_ZEROS + 1;

    logic [DATA_W-1:0] payload;
    assign payload = {ext_code, crc_code, id_code};

    // Header: run of zeros closed by a single one.
    assign frame[HDR_ZEROS-1:0] = '0;
    assign frame[HDR_ZEROS]     = 1'b1;

    // Payload groups: GRP_W data bits then one stuffed control bit.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar k = 0; k < GRP_W; k++) begin : g_bit
            assign frame[HDR_W + g*(GRP_W+1) + k] = payload[g*GRP_W + k];
        end
        assign frame[HDR_W + g*(GRP_W+1) + GRP_W] = 1'b1;
    end

    initial begin
        assert (DATA_W % GRP_W == 0)
            else $error("field widths must be whole stuffing groups");
    end
endmodule

// File: rtl/fdxb_bit_timer.sv
// fdxb_bit_timer: position pointer of the next slot to emit. A slot is
// (clock-in-bit, bit index). It advances every clock and wraps from the
// last clock of the last bit to slot (0,0) with no gap.
// Assumes BIT_CLKS and FRAME_W are at least 2.
module fdxb_bit_timer #(
    parameter int BIT_CLKS = fdxb_pkg::DEF_BIT_CLKS,
    parameter int FRAME_W  = 128,
    parameter int CYC_W    = $clog2(BIT_CLKS),
    parameter int IDX_W    = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CYC_W-1:0] cyc,
    output logic [IDX_W-1:0] bit_no,
    output logic             at_start
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BIT_CLKS - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [IDX_W-1:0] bit_q;

    // Clock-in-bit counter, wrapping at the bit length.
    always_ff @(posedge clk) begin
        if (!rst_n)                cyc_q <= '0;
        else if (cyc_q == LAST_CYC) cyc_q <= '0;
        else                       cyc_q <= cyc_q + 1'b1;
    end

    // Bit counter, stepping after the last clock of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bit_q <= '0;
        else if (cyc_q == LAST_CYC) bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end

    assign cyc      = cyc_q;
    assign bit_no   = bit_q;
    assign at_start = (cyc_q == '0) && (bit_q == '0);

    // R2: the bit position only moves after the last clock of a bit.
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != LAST_CYC) |=> $stable(bit_q));
endmodule

// File: rtl/fdxb_biphase_enc.sv
// fdxb_biphase_enc: differential biphase line coder with falling-edge
// advance. It keeps the nominal line level. The emitted level is that level
// ANDed with the nominal level ADV clocks ahead, so only high-to-low edges
// move earlier. Assumes MAX_ADV < BIT_CLKS/2, so the look-ahead never
// reaches the midpoint of the next bit and needs no data from it.
module fdxb_biphase_enc #(
    parameter int BIT_CLKS = fdxb_pkg::DEF_BIT_CLKS,
    parameter int MAX_ADV  = fdxb_pkg::DEF_MAX_ADV,
    parameter int CYC_W    = $clog2(BIT_CLKS),
    parameter int ADV_W    = $clog2(MAX_ADV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cyc,
    input  logic             data_bit,
    input  logic [ADV_W-1:0] adv,
    output logic             mod_n
);
    localparam int SUM_W = ((CYC_W > ADV_W) ? CYC_W : ADV_W) + 2;
    localparam logic [SUM_W-1:0] HALF_S = SUM_W'(BIT_CLKS / 2);
    localparam logic [SUM_W-1:0] FULL_S = SUM_W'(BIT_CLKS);
    localparam logic [CYC_W-1:0] HALF_C = CYC_W'(BIT_CLKS / 2);

    logic             lvl_q;
    logic             mod_q;
    logic             lvl_next;
    logic             ahead_flip;
    logic [SUM_W-1:0] reach;

    // Nominal level for this slot: toggle at bit start, and at midpoint for a 0.
    always_comb begin
        lvl_next = lvl_q ^ ((cyc == '0) | ((cyc == HALF_C) & ~data_bit));
    end

    // Parity of nominal toggles strictly after this slot and up to ADV ahead.
    always_comb begin
        reach      = SUM_W'(cyc) + SUM_W'(adv);
        ahead_flip = ((SUM_W'(cyc) < HALF_S) & ~data_bit & (reach >= HALF_S))
                   ^ (reach >= FULL_S);
    end

    // Nominal level register; idles high under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_next;
    end

    // Emitted level: low if either now or ADV clocks ahead is low.
    always_ff @(posedge clk) begin
        if (!rst_n) mod_q <= 1'b1;
        else        mod_q <= lvl_next & ~ahead_flip;
    end

    assign mod_n = mod_q;

    // R7: a rising output edge only ever coincides with a rising nominal edge.
    p_rise_unmoved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_q) |-> (lvl_q && !$past(lvl_q)));

    initial begin
        assert (MAX_ADV < BIT_CLKS / 2)
            else $error("advance must stay below half a bit");
    end
endmodule

// File: rtl/fdxb_tx.sv
// fdxb_tx: repeating frame transmitter. It packs the fields into a frame and
// walks it one bit per BIT_CLKS clocks. Each slot is coded as differential
// biphase on an active-low modulation output. Fields and advance are taken
// on the first slot of each frame and held until the next frame.
// All outputs are registered: on each edge they show the slot emitted there.
module fdxb_tx #(
    parameter int BIT_CLKS  = fdxb_pkg::DEF_BIT_CLKS,
    parameter int ID_W      = fdxb_pkg::DEF_ID_W,
    parameter int CRC_W     = fdxb_pkg::DEF_CRC_W,
    parameter int EXT_W     = fdxb_pkg::DEF_EXT_W,
    parameter int GRP_W     = fdxb_pkg::DEF_GRP_W,
    parameter int HDR_ZEROS = fdxb_pkg::DEF_HDR_ZEROS,
    parameter int MAX_ADV   = fdxb_pkg::DEF_MAX_ADV,
    parameter int ADV_IN_W  = fdxb_pkg::DEF_ADV_IN_W,
    localparam int FRAME_W  = fdxb_pkg::frame_len(ID_W, CRC_W, EXT_W, GRP_W, HDR_ZEROS),
    localparam int IDX_W    = $clog2(FRAME_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     id_code,
    input  logic [CRC_W-1:0]    crc_code,
    input  logic [EXT_W-1:0]    ext_code,
    input  logic [ADV_IN_W-1:0] adv_in,
    output logic                mod_n,
    output logic [IDX_W-1:0]    bit_idx,
    output logic                frame_start
);
    localparam int CYC_W = $clog2(BIT_CLKS);
    localparam int ADV_W = $clog2(MAX_ADV + 1);

    logic [FRAME_W-1:0] packed_frame;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] cur_frame;
    logic [ADV_W-1:0]   adv_clamped;
    logic [ADV_W-1:0]   adv_q;
    logic [ADV_W-1:0]   cur_adv;
    logic [CYC_W-1:0]   slot_cyc;
    logic [IDX_W-1:0]   slot_bit;
    logic               slot_start;
    logic [IDX_W-1:0]   idx_q;
    logic               start_q;

    fdxb_frame_pack #(
        .ID_W(ID_W), .CRC_W(CRC_W), .EXT_W(EXT_W),
        .GRP_W(GRP_W), .HDR_ZEROS(HDR_ZEROS), .FRAME_W(FRAME_W)
    ) u_pack (
        .id_code (id_code),
        .crc_code(crc_code),
        .ext_code(ext_code),
        .frame   (packed_frame)
    );

    fdxb_bit_timer #(
        .BIT_CLKS(BIT_CLKS), .FRAME_W(FRAME_W), .CYC_W(CYC_W), .IDX_W(IDX_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (slot_cyc),
        .bit_no  (slot_bit),
        .at_start(slot_start)
    );

    // Saturate the requested advance to the supported maximum.
    always_comb begin
        if (int'(adv_in) > MAX_ADV) adv_clamped = ADV_W'(MAX_ADV);
        else                        adv_clamped = ADV_W'(adv_in);
    end

    // On the first slot use the live inputs; afterwards the held copies.
    always_comb begin
        cur_frame = slot_start ? packed_frame : frame_q;
        cur_adv   = slot_start ? adv_clamped  : adv_q;
    end

    // Hold frame and advance for the remainder of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            adv_q   <= '0;
        end else if (slot_start) begin
            frame_q <= packed_frame;
            adv_q   <= adv_clamped;
        end
    end

    // Register the slot position and start strobe alongside the line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            idx_q   <= slot_bit;
            start_q <= slot_start;
        end
    end

    fdxb_biphase_enc #(
        .BIT_CLKS(BIT_CLKS), .MAX_ADV(MAX_ADV), .CYC_W(CYC_W), .ADV_W(ADV_W)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (slot_cyc),
        .data_bit(cur_frame[slot_bit]),
        .adv     (cur_adv),
        .mod_n   (mod_n)
    );

    assign bit_idx     = idx_q;
    assign frame_start = start_q;

    // R3: the start strobe only appears on frame position 0.
    p_start_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (idx_q == '0));

    // R9: held frame contents change only on a frame's first slot.
    p_frame_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> ($stable(frame_q) && $stable(adv_q)));

    // R8: the held advance never exceeds the supported maximum.
    p_adv_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(adv_q) <= MAX_ADV);
endmodule

// File: tb/fdxb_tx_bench.sv
// fdxb_tx_bench: behavioural reference model of the transmitter, compared
// with the design's outputs after every clock edge.
module fdxb_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] id_code = '0;
    logic [15:0] crc_code = '0;
    logic [23:0] ext_code = '0;
    logic [3:0]  adv_in = '0;
    logic        mod_n;
    logic [6:0]  bit_idx;
    logic        frame_start;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Model state.
    int           t_slot = 0;
    bit           lvl = 1'b1;
    logic [127:0] mfr = '0;
    int           madv = 0;
    int           raw_adv = 0;
    bit           mid_change = 0;

    always #4 clk = ~clk;

    fdxb_tx u_fdxb_tx (
        .clk(clk), .rst_n(rst_n), .id_code(id_code), .crc_code(crc_code),
        .ext_code(ext_code), .adv_in(adv_in), .mod_n(mod_n),
        .bit_idx(bit_idx), .frame_start(frame_start)
    );

    // Build the expected frame from the field values (layout of R6).
    function automatic logic [127:0] build_frame(logic [63:0] id, logic [15:0] crc,
                                                 logic [23:0] ext);
        logic [127:0] f;
        int pos;
        f = '0;
        pos = 0;
        for (int i = 0; i < 10; i++) begin f[pos] = 1'b0; pos++; end
        f[pos] = 1'b1; pos++;
        for (int n = 0; n < 104; n++) begin
            if (n < 64)      f[pos] = id[n];
            else if (n < 80) f[pos] = crc[n-64];
            else             f[pos] = ext[n-80];
            pos++;
            if (n % 8 == 7) begin f[pos] = 1'b1; pos++; end
        end
        return f;
    endfunction

    // Nominal level a clocks ahead of slot (b,c) with level l.
    function automatic bit look_ahead(int b, int c, bit l, int a, logic [127:0] fr);
        for (int i = 0; i < a; i++) begin
            c++;
            if (c == 32) begin c = 0; b = (b + 1) % 128; l = ~l; end
            else if (c == 16 && !fr[b]) l = ~l;
        end
        return l;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s at slot %0d: actual=%0d expected=%0d",
                     tag, what, t_slot, act, exp);
        end
    endtask

    // One clock: update the model for this edge, then compare after the edge.
    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            int    b, c, e_mod, e_idx, e_start;
            string tag;
            if (!rst_n) begin
                e_mod = 1; e_idx = 0; e_start = 0;
                t_slot = 0; lvl = 1'b1; mid_change = 0;
                tag = "R1";
            end else begin
                c = t_slot % 32;
                b = (t_slot / 32) % 128;
                if (t_slot % 4096 == 0) begin
                    mfr = build_frame(id_code, crc_code, ext_code);
                    raw_adv = int'(adv_in);
                    madv = (raw_adv > 8) ? 8 : raw_adv;
                    mid_change = 0;
                end
                if (c == 0) lvl = ~lvl;
                else if (c == 16 && !mfr[b]) lvl = ~lvl;
                e_mod   = int'(lvl & look_ahead(b, c, lvl, madv, mfr));
                e_idx   = b;
                e_start = (t_slot % 4096 == 0) ? 1 : 0;
                if (mid_change)                  tag = "R9";
                else if (raw_adv > 8)            tag = "R8";
                else if (madv > 0)               tag = "R7";
                else if (b == 0)                 tag = "R4";
                else if (b < 11 || ((b - 11) % 9 == 8)) tag = "R6";
                else                             tag = "R5";
                t_slot++;
            end
            @(posedge clk);
            #2;
            check(tag, int'(mod_n), e_mod, "mod_n");
            check(rst_n ? "R2" : "R1", int'(bit_idx), e_idx, "bit_idx");
            check(rst_n ? "R3" : "R1", int'(frame_start), e_start, "frame_start");
        end
    endtask

    // Change inputs away from a frame start and remember it for tagging (R9).
    task automatic change_mid(logic [63:0] id, logic [15:0] crc, logic [23:0] ext,
                              logic [3:0] adv);
        id_code = id; crc_code = crc; ext_code = ext; adv_in = adv;
        if (t_slot % 4096 != 0) mid_change = 1;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #1;
        id_code  = 64'h0123_4567_89AB_CDEF;
        crc_code = 16'hA5C3;
        ext_code = 24'h80_0001;
        adv_in   = 4'd0;
        tick(3);                     // R1 reset state
        rst_n = 1'b1;
        tick(2048);                  // R4/R5/R6 first half frame, advance 0
        change_mid(64'hFFFF_0000_F0F0_00FF, 16'h0001, 24'hFFFFFF, 4'd5);
        tick(2048);                  // R9 rest of frame unaffected
        tick(4096);                  // R7 advance 5
        change_mid(64'h0, 16'hFFFF, 24'h5A5A5A, 4'd8);
        tick(4096);                  // R7 advance 8, wrap look-ahead
        change_mid(64'hAAAA_5555_3333_CCCC, 16'h1234, 24'h00FF00, 4'd15);
        tick(4096);                  // R8 clamped advance
        change_mid(64'hDEAD_BEEF_0BAD_F00D, 16'h7E81, 24'h135799, 4'd2);
        tick(5000);                  // R7 advance 2, then mid-frame reset
        rst_n = 1'b0;
        tick(3);                     // R1 reset from non-zero position
        rst_n = 1'b1;
        id_code = '1; crc_code = '1; ext_code = '1; adv_in = 4'd0;
        tick(4200);                  // R2/R3 restart and wrap
        finished = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100000 * 8);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule